// File: doc/BRIEF.md
# Low-Power Event Counter with Compare Match

This block is a 16-bit up-counter that runs in one of two modes. In time mode it advances on a prescaler strobe. It uses either the raw prescaler clock strobe or the divided prescaler output, depending on a bypass bit. In pulse mode it advances on each new assertion of an external input. It uses either the raw input, with its own rising-edge detector, or a strobe from an external glitch filter. The prescaler divider and the glitch filter are outside this block and reach it only as single-cycle strobes.

A programmable compare value is checked against the count. A match event occurs when the count already equals the compare value and an increment arrives. The event does three things:

- It sets a sticky flag.
- It fires a one-cycle trigger.
- It raises the interrupt when interrupts are enabled.

The count then either restarts from zero or keeps running, as software selects. While the block is enabled and the flag is clear, writes to the compare value are refused. Software cannot load the count. A write to the count address latches the live count into a holding register, and reads of that address return the holding register. When debug halt is asserted, time mode freezes but pulse mode keeps counting.

Register map (16-bit data):

- Address 0 is control.
  - bit0: enable
  - bit1: mode (1 = pulse)
  - bit2: prescaler bypass
  - bit3: filter bypass
  - bit4: interrupt enable
  - bit5: free-run
  - bit7: flag (read), write 1 to clear
- Address 1 is the compare value.
- Address 2 is the count snapshot.
- Address 3 reads as zero.

Top module: `lpct_top`

## Requirements
- R1: After reset the control bits, flag, compare value, snapshot, interrupt and trigger are all zero.
- R2: In time mode with enable=1, the count rises by one on each cycle with `presc_clk` high when bit2=1, or with `presc_out` high when bit2=0; the other strobe has no effect.
- R3: In pulse mode with bit3=1, the count rises by one on each 0-to-1 transition of `pin_in`; with bit3=0 it rises on each cycle with `filt_pulse` high, and `pin_in` edges have no effect. With bit3=1, `filt_pulse` has no effect.
- R4: While disabled the previous input level is held at 1, so an input already high when enable is set causes no increment.
- R5: When the count equals the compare value and an increment arrives, the flag (control bit7) is set, `trig` is high for the following cycle, and `irq` equals flag AND bit4.
- R6: With bit5=0 the count goes to zero on a match event; with bit5=1 it continues to count+1, wrapping to zero only after 0xFFFF.
- R7: The count is zero on the cycle after enable is seen low.
- R8: A compare write takes effect when enable is 0 or the flag is 1; otherwise it is ignored and the old value stays readable.
- R9: While `dbg_halt` is high, time mode does not count, while pulse mode keeps counting.
- R10: Any write to address 2 copies the current count into the snapshot; reads of address 2 return the snapshot.
- R11: Writing control with bit7=1 clears the flag unless a match event occurs in the same cycle; otherwise the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_halt | input | 1 | Core halted for debug |
| presc_clk | input | 1 | Prescaler clock strobe |
| presc_out | input | 1 | Prescaler divided output strobe |
| pin_in | input | 1 | Selected pulse input level |
| filt_pulse | input | 1 | Glitch-filter output strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request, flag AND interrupt enable |
| trig | output | 1 | One-cycle match trigger |

## Verification
The embedded properties check these rules on every cycle:

- The counter only holds, steps by one or returns to zero.
- Disable clears it.
- A match without free-run restarts it.
- A trigger is always accompanied by a set flag.
- Refused compare writes leave the compare value unchanged.
- The snapshot equals the prior count after a capture.
- The flag stays set until cleared.
- No increment is counted on the first enabled cycle of bypassed pulse mode.
- A time-mode halt freezes the count.

Other behaviours need scenarios and can only be shown by the bench:

- The exact cycle of the match relative to the increment.
- Strobe selection per mode.
- Wrap after 0xFFFF.
- Counting continuing under halt in pulse mode.
- The readback values.

// File: rtl/lpct_pkg.sv
package lpct_pkg;

  localparam int unsigned LPCT_CNT_W = 16;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CMP  = 2'd1,
    A_CNT  = 2'd2,
    A_NONE = 2'd3
  } lpct_addr_e;

  // control field positions (software visible)
  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_PULS = 1;
  localparam int unsigned B_PBYP = 2;
  localparam int unsigned B_FBYP = 3;
  localparam int unsigned B_TIE  = 4;
  localparam int unsigned B_FREE = 5;
  localparam int unsigned B_FLAG = 7;

  typedef struct packed {
    logic free_run;
    logic irq_en;
    logic filt_byp;
    logic presc_byp;
    logic pulse_mode;
    logic en;
  } lpct_cfg_t;

endpackage

// File: rtl/lpct_rst_sync.sv
module lpct_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[LAST];
endmodule

// File: rtl/lpct_regs.sv
module lpct_regs
  import lpct_pkg::*;
#(
  parameter int unsigned CNT_W = LPCT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             flag,
  output lpct_cfg_t        cfg,
  output logic [CNT_W-1:0] cmp,
  output logic             flag_clr,
  output logic [CNT_W-1:0] bus_rdata
);
  localparam int unsigned CTRL_W = B_FLAG + 1;

  lpct_cfg_t        cfg_q, cfg_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W-1:0] snap_q, snap_d;
  logic             ctrl_we, cmp_we, snap_we;
  logic [CTRL_W-1:0] ctrl_view;
  logic             wdata_unused;

  assign wdata_unused = ^bus_wdata[CNT_W-1:B_FLAG+1] ^ bus_wdata[6];

  // write decode; compare is locked while running with flag clear
  always_comb begin
    ctrl_we  = bus_wr && (bus_addr == A_CTRL);
    cmp_we   = bus_wr && (bus_addr == A_CMP) && (!cfg_q.en || flag);
    snap_we  = bus_wr && (bus_addr == A_CNT);
    flag_clr = ctrl_we && bus_wdata[B_FLAG];
  end

  always_comb begin
    cfg_d  = cfg_q;
    cmp_d  = cmp_q;
    snap_d = snap_q;
    if (ctrl_we) begin
      cfg_d.en         = bus_wdata[B_EN];
      cfg_d.pulse_mode = bus_wdata[B_PULS];
      cfg_d.presc_byp  = bus_wdata[B_PBYP];
      cfg_d.filt_byp   = bus_wdata[B_FBYP];
      cfg_d.irq_en     = bus_wdata[B_TIE];
      cfg_d.free_run   = bus_wdata[B_FREE];
    end
    if (cmp_we)  cmp_d  = bus_wdata;
    if (snap_we) snap_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cmp_q  <= '0;
      snap_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      cmp_q  <= cmp_d;
      snap_q <= snap_d;
    end
  end

  always_comb begin
    ctrl_view         = '0;
    ctrl_view[B_EN]   = cfg_q.en;
    ctrl_view[B_PULS] = cfg_q.pulse_mode;
    ctrl_view[B_PBYP] = cfg_q.presc_byp;
    ctrl_view[B_FBYP] = cfg_q.filt_byp;
    ctrl_view[B_TIE]  = cfg_q.irq_en;
    ctrl_view[B_FREE] = cfg_q.free_run;
    ctrl_view[B_FLAG] = flag;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_view;
      A_CMP:   bus_rdata = cmp_q;
      A_CNT:   bus_rdata = snap_q;
      default: bus_rdata = '0;
    endcase
  end

  assign cfg = cfg_q;
  assign cmp = cmp_q;

  AST_CMP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CMP && cfg_q.en && !flag) |=> $stable(cmp_q)); // R8
  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CNT) |=> (snap_q == $past(cnt))); // R10
endmodule

// File: rtl/lpct_src.sv
module lpct_src
  import lpct_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lpct_cfg_t cfg,
  input  logic      dbg_halt,
  input  logic      presc_clk,
  input  logic      presc_out,
  input  logic      pin_in,
  input  logic      filt_pulse,
  output logic      inc
);
  logic prev_q, prev_d;
  logic pin_rise, time_evt, pulse_evt;

  // previous level is forced high while stopped, so a high input at start is not an edge
  always_comb begin
    prev_d = cfg.en ? pin_in : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  always_comb begin
    pin_rise  = pin_in && !prev_q;
    time_evt  = !dbg_halt && (cfg.presc_byp ? presc_clk : presc_out);
    pulse_evt = cfg.filt_byp ? pin_rise : filt_pulse;
    inc       = cfg.en && (cfg.pulse_mode ? pulse_evt : time_evt);
  end

  AST_NO_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && !$past(cfg.en) && cfg.pulse_mode && cfg.filt_byp) |-> !inc); // R4
  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && $past(cfg.en) && cfg.pulse_mode && cfg.filt_byp && inc)
      |-> (pin_in && !$past(pin_in))); // R3
endmodule

// File: rtl/lpct_core.sv
module lpct_core
  import lpct_pkg::*;
#(
  parameter int unsigned CNT_W = LPCT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             free_run,
  input  logic             inc,
  input  logic [CNT_W-1:0] cmp,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             trig
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             trig_q, trig_d;
  logic             hit;

  // match needs the count sitting on compare AND an increment arriving
  always_comb begin
    hit = inc && (cnt_q == cmp);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!en)                   cnt_d = '0;
    else if (hit && !free_run) cnt_d = '0;
    else if (inc)              cnt_d = cnt_q + ONE;
    flag_d = hit || (flag_q && !flag_clr);
    trig_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      trig_q <= trig_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;
  assign trig = trig_q;

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0)); // R7
  AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit && !free_run) |=> (cnt_q == '0)); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == '0))); // R6
  AST_TRIG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> flag_q); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R11
endmodule

// File: rtl/lpct_top.sv
module lpct_top
  import lpct_pkg::*;
#(
  parameter int unsigned CNT_W    = LPCT_CNT_W,
  parameter int unsigned RST_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_halt,
  input  logic             presc_clk,
  input  logic             presc_out,
  input  logic             pin_in,
  input  logic             filt_pulse,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq,
  output logic             trig
);
  logic             rst_int_n;
  lpct_cfg_t        cfg;
  logic [CNT_W-1:0] cmp, cnt;
  logic             flag, flag_clr, inc;

  lpct_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  lpct_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt),
    .flag      (flag),
    .cfg       (cfg),
    .cmp       (cmp),
    .flag_clr  (flag_clr),
    .bus_rdata (bus_rdata)
  );

  lpct_src u_src (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg        (cfg),
    .dbg_halt   (dbg_halt),
    .presc_clk  (presc_clk),
    .presc_out  (presc_out),
    .pin_in     (pin_in),
    .filt_pulse (filt_pulse),
    .inc        (inc)
  );

  lpct_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (cfg.en),
    .free_run (cfg.free_run),
    .inc      (inc),
    .cmp      (cmp),
    .flag_clr (flag_clr),
    .cnt      (cnt),
    .flag     (flag),
    .trig     (trig)
  );

  assign irq = flag && cfg.irq_en;

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg.en && !cfg.pulse_mode && dbg_halt) |=> ((cnt == $past(cnt)) || (cnt == '0))); // R9
endmodule

// File: tb/sim_lpct_top.sv
module sim_lpct_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dbg_halt, presc_clk, presc_out, pin_in, filt_pulse, bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq, trig;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  lpct_top u0 (
    .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .presc_clk(presc_clk),
    .presc_out(presc_out), .pin_in(pin_in), .filt_pulse(filt_pulse),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .trig(trig)
  );

  // ---------------- reference model, from the requirements ----------------
  logic [5:0]  m_cfg;   // en, pulse, pbyp, fbyp, tie, free
  logic [15:0] m_cnt, m_cmp, m_snap;
  logic        m_flag, m_trig, m_prev;

  function automatic logic m_inc_f(logic [5:0] c, logic prev);
    logic rise;
    rise = pin_in & ~prev;
    if (!c[0]) return 1'b0;
    if (c[1])  return c[3] ? rise : filt_pulse;
    return ~dbg_halt & (c[2] ? presc_clk : presc_out);
  endfunction

  function automatic logic [15:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0:    return {8'h00, m_flag, 1'b0, m_cfg};
      2'd1:    return m_cmp;
      2'd2:    return m_snap;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = '0; m_cnt = '0; m_cmp = '0; m_snap = '0;
      m_flag = 1'b0; m_trig = 1'b0; m_prev = 1'b1;
    end else begin
      automatic logic        inc = m_inc_f(m_cfg, m_prev);
      automatic logic        hit = inc && (m_cnt == m_cmp);
      automatic logic [15:0] ncnt;
      automatic logic        nflag;
      if (!m_cfg[0])             ncnt = 16'h0;
      else if (hit && !m_cfg[5]) ncnt = 16'h0;
      else if (inc)              ncnt = m_cnt + 16'h1;
      else                       ncnt = m_cnt;
      nflag = hit || (m_flag && !(bus_wr && bus_addr == 2'd0 && bus_wdata[7]));
      if (bus_wr && bus_addr == 2'd1 && (!m_cfg[0] || m_flag)) m_cmp = bus_wdata;
      if (bus_wr && bus_addr == 2'd2) m_snap = m_cnt;
      m_prev = m_cfg[0] ? pin_in : 1'b1;
      if (bus_wr && bus_addr == 2'd0) m_cfg = bus_wdata[5:0];
      m_trig = hit;
      m_cnt  = ncnt;
      m_flag = nflag;
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({15'b0, trig}, {15'b0, m_trig}, "R5 trig vs model");
      chk({15'b0, irq}, {15'b0, m_flag & m_cfg[4]}, "R5 irq vs model");
      case (bus_addr)
        2'd0:    chk(bus_rdata, exp_rd(bus_addr), "R11 ctrl/flag readback");
        2'd1:    chk(bus_rdata, exp_rd(bus_addr), "R8 compare readback");
        2'd2:    chk(bus_rdata, exp_rd(bus_addr), "R10 snapshot readback");
        default: chk(bus_rdata, exp_rd(bus_addr), "R1 unused address");
      endcase
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic read_cnt(output logic [15:0] v);
    wr(2'd2, 16'h0);
    rd(2'd2, v);
  endtask

  task automatic pclk(input int n);
    presc_clk = 1'b1; repeat (n) step(); presc_clk = 1'b0;
  endtask

  task automatic pout(input int n);
    presc_out = 1'b1; repeat (n) step(); presc_out = 1'b0;
  endtask

  task automatic filt(input int n);
    filt_pulse = 1'b1; repeat (n) step(); filt_pulse = 1'b0;
  endtask

  task automatic rises(input int n);
    repeat (n) begin pin_in = 1'b0; step(); pin_in = 1'b1; step(); end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  // ---------------- test sequence ----------------
  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    rst_n = 1'b0; dbg_halt = 0; presc_clk = 0; presc_out = 0; pin_in = 0;
    filt_pulse = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    rd(2'd0, v); chk(v, 16'h0, "R1 ctrl after reset");
    rd(2'd1, v); chk(v, 16'h0, "R1 compare after reset");
    rd(2'd2, v); chk(v, 16'h0, "R1 snapshot after reset");
    chk({15'b0, irq}, 16'h0, "R1 irq after reset");
    chk({15'b0, trig}, 16'h0, "R1 trig after reset");

    // R2 time mode, bypass then divided strobe
    wr(2'd1, 16'd100);
    wr(2'd0, 16'h0015);
    pclk(5); pout(3);
    read_cnt(v); chk(v, 16'd5, "R2 prescaler clock counted, output ignored");
    wr(2'd0, 16'h0011);
    pout(2); pclk(2);
    read_cnt(v); chk(v, 16'd7, "R2 prescaler output counted, clock ignored");

    // R9 halt freezes time mode
    dbg_halt = 1'b1; pout(3); dbg_halt = 1'b0;
    read_cnt(v); chk(v, 16'd7, "R9 time mode frozen in halt");

    // R7 disable clears
    wr(2'd0, 16'h0000); step();
    read_cnt(v); chk(v, 16'd0, "R7 count cleared when disabled");

    // R5/R6 match with restart
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h0015);
    pclk(3);
    chk({15'b0, irq}, 16'h0, "R5 no event at equality without increment");
    read_cnt(v); chk(v, 16'd3, "R5 count sits on compare");
    presc_clk = 1'b1; step();
    chk({15'b0, trig}, 16'h1, "R5 trigger after matching increment");
    chk({15'b0, irq}, 16'h1, "R5 irq with enable");
    presc_clk = 1'b0; step();
    chk({15'b0, trig}, 16'h0, "R5 trigger one cycle only");
    read_cnt(v); chk(v, 16'd0, "R6 restart on match");
    rd(2'd0, v); chk({15'b0, v[7]}, 16'h1, "R5 flag set");

    // R8 compare lock, R11 flag clear
    wr(2'd1, 16'd5);
    rd(2'd1, v); chk(v, 16'd5, "R8 write accepted with flag set");
    wr(2'd0, 16'h0095);
    chk({15'b0, irq}, 16'h0, "R11 flag cleared by write one");
    wr(2'd1, 16'd9);
    rd(2'd1, v); chk(v, 16'd5, "R8 write refused with flag clear");

    // R6 free-run and overflow wrap
    wr(2'd0, 16'h0000); step();
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0035);
    pclk(3);
    read_cnt(v); chk(v, 16'd3, "R6 free-run continues past match");
    rd(2'd0, v); chk({15'b0, v[7]}, 16'h1, "R5 flag set in free-run");
    pclk(65533);
    read_cnt(v); chk(v, 16'd0, "R6 wrap after 0xFFFF");

    // R4/R3 pulse mode
    wr(2'd0, 16'h0000); step();
    pin_in = 1'b1;
    wr(2'd1, 16'd1000);
    wr(2'd0, 16'h000B);
    repeat (4) step();
    read_cnt(v); chk(v, 16'd0, "R4 high input at enable not counted");
    rises(3); filt(2);
    read_cnt(v); chk(v, 16'd3, "R3 edges counted, filter strobe ignored");
    dbg_halt = 1'b1; rises(2); dbg_halt = 1'b0;
    read_cnt(v); chk(v, 16'd5, "R9 pulse mode counts in halt");
    wr(2'd0, 16'h0003);
    rises(2); filt(4);
    read_cnt(v); chk(v, 16'd9, "R3 filter strobe counted, edges ignored");

    // constrained random against the model
    for (int i = 0; i < 5000; i++) begin
      presc_clk  = ($urandom % 3) == 0;
      presc_out  = ($urandom % 4) == 0;
      pin_in     = $urandom % 2;
      filt_pulse = ($urandom % 5) == 0;
      dbg_halt   = ($urandom % 6) == 0;
      bus_addr   = 2'($urandom % 4);
      bus_wr     = ($urandom % 5) == 0;
      bus_wdata  = 16'($urandom);
      if (bus_addr == 2'd0) bus_wdata[0] = ($urandom % 8) != 0;
      if (bus_addr == 2'd1) bus_wdata = 16'($urandom % 12);
      step();
    end
    bus_wr = 1'b0;
    step();
    summary();
  end
endmodule